// File: doc/BRIEF.md
# Rise-Time and Timestamp Digitizer

This block turns two comparator events from one detector channel into digital numbers by counting clock cycles. A rising edge on the onset comparator (threshold on a fast shaper) starts a measurement and captures the current value of a free-running timestamp counter. A rising edge on the end-of-rise comparator stops a second counter, and that count is the rise time. The readout logic uses the rise time to correct pulse amplitude for interaction depth.

Each counter has its own 2-bit resolution setting that divides its count rate by 1, 2, 4 or 8. Once a measurement completes, both results are held and flagged valid until the readout logic collects them with a clear pulse. Onset edges that arrive while a result is in flight or held are dropped. The analogue shaping and discrimination are outside the block: both comparator outputs arrive as synchronous digital levels.

Top module: `rise_stamp_digitizer`

## Requirements
- R1: While `rst_n` is low, `hold_valid_o` is 0. Internal logic leaves reset on the second rising clock edge after `rst_n` goes high. The first edge that sees it active is the third one.
- R2: A rising edge on `onset_i` (high this cycle, low the cycle before) while idle starts a measurement. When the result is held, `stamp_o` equals the timestamp value present in the cycle of that edge, before that cycle's update.
- R3: If the `rise_end_i` rising edge comes k cycles after the onset edge, the held `rise_cnt_o` equals floor(k / 2^r). Here r is the value of `rise_scale_i` sampled in the onset-edge cycle. `hold_valid_o` rises one cycle after the `rise_end_i` edge.
- R4: The rise count saturates at all-ones (255 for the 8-bit default) when the end edge is late, and it never wraps.
- R5: The timestamp is an 8-bit wrapping counter driven by a 3-bit free-running cycle phase. In each cycle where the low `stamp_scale_i` bits of the phase are all ones, the timestamp steps by 1. With scale s this is once every 2^s cycles.
- R6: While `hold_valid_o` is 1 and `collect_i` is 0, `rise_cnt_o` and `stamp_o` keep their values. Further `rise_end_i` edges have no effect.
- R7: `onset_i` edges that arrive while a measurement is running or a result is held are ignored. This holds even in the cycle in which `collect_i` releases the hold.
- R8: `collect_i` high while the result is held drops `hold_valid_o` on the next cycle and makes the block idle. `collect_i` at any other time has no effect.
- R9: The onset input is edge-sensitive. If `onset_i` stays high across a collect, no new measurement starts until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| onset_i | input | 1 | Onset comparator level (fast shaper threshold) |
| rise_end_i | input | 1 | End-of-rise comparator level |
| collect_i | input | 1 | Readout has taken the held result |
| stamp_scale_i | input | 2 | Timestamp resolution: divide by 2^value |
| rise_scale_i | input | 2 | Rise-time resolution: divide by 2^value |
| hold_valid_o | output | 1 | Held result is valid |
| rise_cnt_o | output | 8 | Rise-time count |
| stamp_o | output | 8 | Timestamp captured at onset |

## Verification
The bench targets several corner cases. The rise count must be floor(k/2^r) at every scale. A counter that ticks on the wrong phase gives counts that are off by one. A late end edge must give 255, and a design that wraps would show a small count instead. Onset pulses sent during a measurement, during a hold and in the collect cycle itself must leave the stamp unchanged, and a design that re-arms early would overwrite it. A level held high across a collect must not start a second measurement, and a level-sensitive design would show a spurious valid.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } rtd_state_e;
endpackage

// File: rtl/rtd_rst_sync.sv
module rtd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/rtd_rise_edge.sv
module rtd_rise_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign edge_o = level_i & ~prev_q;
endmodule

// File: rtl/rtd_tick_counter.sv
module rtd_tick_counter #(
  parameter int RES_W    = 2,
  parameter int CNT_W    = 8,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int DIV_W = (1 << RES_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             tick;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(res_i));
  end

  assign tick = en_i && ((div_q & mask) == mask);

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
    end
  endgenerate

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      div_d = '0;
      cnt_d = '0;
    end else if (en_i) begin
      div_d = div_q + 1'b1;
      if (tick) cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rise_stamp_digitizer.sv
module rise_stamp_digitizer #(
  parameter int RES_W = 2,
  parameter int RT_W  = 8,
  parameter int TS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             onset_i,
  input  logic             rise_end_i,
  input  logic             collect_i,
  input  logic [RES_W-1:0] stamp_scale_i,
  input  logic [RES_W-1:0] rise_scale_i,
  output logic             hold_valid_o,
  output logic [RT_W-1:0]  rise_cnt_o,
  output logic [TS_W-1:0]  stamp_o
);
  import rtd_pkg::*;

  logic             rst_int_n;
  logic             onset_edge, end_edge;
  logic             accept, run_en;
  rtd_state_e       state_q, state_d;
  logic [RES_W-1:0] rscale_q, rscale_d;
  logic [TS_W-1:0]  stamp_q, stamp_d, ts_now;

  rtd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n));

  rtd_rise_edge u_onset (.clk(clk), .rst_n(rst_int_n), .level_i(onset_i),
                         .edge_o(onset_edge));
  rtd_rise_edge u_end   (.clk(clk), .rst_n(rst_int_n), .level_i(rise_end_i),
                         .edge_o(end_edge));

  rtd_tick_counter #(.RES_W(RES_W), .CNT_W(TS_W), .SATURATE(1'b0)) u_ts (
    .clk(clk), .rst_n(rst_int_n), .clr_i(1'b0), .en_i(1'b1),
    .res_i(stamp_scale_i), .cnt_o(ts_now));

  assign accept = (state_q == ST_IDLE) && onset_edge;
  assign run_en = (state_q == ST_RUN);

  rtd_tick_counter #(.RES_W(RES_W), .CNT_W(RT_W), .SATURATE(1'b1)) u_rt (
    .clk(clk), .rst_n(rst_int_n), .clr_i(accept), .en_i(run_en),
    .res_i(rscale_q), .cnt_o(rise_cnt_o));

  always_comb begin
    state_d  = state_q;
    rscale_d = rscale_q;
    stamp_d  = stamp_q;
    unique case (state_q)
      ST_IDLE: if (onset_edge) begin
        state_d  = ST_RUN;
        rscale_d = rise_scale_i;
        stamp_d  = ts_now;
      end
      ST_RUN:  if (end_edge)  state_d = ST_HOLD;
      ST_HOLD: if (collect_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      rscale_q <= '0;
      stamp_q  <= '0;
    end else begin
      state_q  <= state_d;
      rscale_q <= rscale_d;
      stamp_q  <= stamp_d;
    end
  end

  assign hold_valid_o = (state_q == ST_HOLD);
  assign stamp_o      = stamp_q;
endmodule

// File: rtl/rtd_checker.sv
module rtd_checker #(
  parameter int RT_W = 8,
  parameter int TS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rise_end_i,
  input logic            collect_i,
  input logic            hold_valid_o,
  input logic [RT_W-1:0] rise_cnt_o,
  input logic [TS_W-1:0] stamp_o,
  input logic [1:0]      st
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!hold_valid_o);
  end

  assert_done_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_valid_o) |-> ($past(rise_end_i) && !$past(rise_end_i, 2)));

  assert_count_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> (rise_cnt_o >= $past(rise_cnt_o)));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd1) && (rise_cnt_o == {RT_W{1'b1}})) |=> (rise_cnt_o == {RT_W{1'b1}}));

  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid_o && !collect_i) |=>
      (hold_valid_o && $stable(rise_cnt_o) && $stable(stamp_o)));

  assert_stamp_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> $stable(stamp_o));

  assert_collect_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid_o && collect_i) |=> !hold_valid_o);
endmodule

bind rise_stamp_digitizer rtd_checker #(.RT_W(RT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_end_i(rise_end_i), .collect_i(collect_i),
  .hold_valid_o(hold_valid_o), .rise_cnt_o(rise_cnt_o), .stamp_o(stamp_o),
  .st(state_q));

// File: tb/sim_rise_stamp_digitizer.sv
module sim_rise_stamp_digitizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       onset = 1'b0, rend = 1'b0, collect = 1'b0;
  logic [1:0] ts_sc = 2'd0, rt_sc = 2'd0;
  logic       valid;
  logic [7:0] rise, stamp;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit wd_hit = 1'b0;

  // reference model state
  bit p1 = 0, p2 = 0, pon = 0, pend = 0;
  int st = 0, k = 0, res = 0, m_stamp = 0, m_rise = 0, tdiv = 0, ts = 0;

  always #10 clk = ~clk;

  rise_stamp_digitizer u0 (
    .clk(clk), .rst_n(rst_n), .onset_i(onset), .rise_end_i(rend),
    .collect_i(collect), .stamp_scale_i(ts_sc), .rise_scale_i(rt_sc),
    .hold_valid_o(valid), .rise_cnt_o(rise), .stamp_o(stamp));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; pon = 0; pend = 0; st = 0; k = 0; res = 0;
      tdiv = 0; ts = 0; m_stamp = 0; m_rise = 0;
    end else begin
      bit active, sr, er;
      int msk;
      active = p2; p2 = p1; p1 = 1;
      if (active) begin
        sr = onset && !pon;
        er = rend && !pend;
        if (st == 0) begin
          if (sr) begin st = 1; m_stamp = ts; k = 0; res = int'(rt_sc); end
        end else if (st == 1) begin
          k++;
          if (er) begin
            st = 2;
            m_rise = (k >> res) > 255 ? 255 : (k >> res);
          end
        end else if (collect) st = 0;
        msk = (1 << int'(ts_sc)) - 1;
        if ((tdiv & msk) == msk) ts = (ts + 1) % 256;
        tdiv = (tdiv + 1) % 8;
        pon = onset; pend = rend;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (valid !== (st == 2)) begin
      fails++;
      $display("FAIL %s valid: actual %0b expected %0b", cur_req, valid, st == 2);
    end
    if (st == 2 && valid === 1'b1) begin
      checks++;
      if (int'(rise) != m_rise || int'(stamp) != m_stamp) begin
        fails++;
        $display("FAIL %s rise/stamp: actual %0d/%0d expected %0d/%0d",
                 cur_req, rise, stamp, m_rise, m_stamp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic collect_now();
    collect = 1'b1; cyc(1); collect = 1'b0; cyc(2);
  endtask

  task automatic measure(int kk, int rs, int tss);
    rt_sc = 2'(rs); ts_sc = 2'(tss);
    onset = 1'b1; cyc(1);
    rt_sc = 2'(3 - rs);            // changes after onset must not matter (R3)
    cyc(kk - 1);
    rend = 1'b1; cyc(1);
    onset = 1'b0; cyc(1);
    rend = 1'b0; cyc(3);
  endtask

  task automatic run_all();
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    cur_req = "R3";
    measure(3, 0, 0);  collect_now();
    measure(26, 0, 1); collect_now();
    for (int r = 0; r < 4; r++) begin
      measure(37 + r, r, r); collect_now();
    end
    cur_req = "R5";
    ts_sc = 2'd2; cyc(19);
    measure(8, 1, 3); collect_now();
    ts_sc = 2'd0; cyc(250);
    measure(5, 0, 0); collect_now();
    cur_req = "R4";
    measure(300, 0, 0);  collect_now();
    measure(1300, 2, 1); collect_now();
    cur_req = "R7";
    rt_sc = 2'd0; onset = 1'b1; cyc(2); onset = 1'b0; cyc(4);
    onset = 1'b1; cyc(1); onset = 1'b0; cyc(4);    // ignored while running
    rend = 1'b1; cyc(1); rend = 1'b0; cyc(2);
    onset = 1'b1; cyc(1); onset = 1'b0; cyc(2);    // ignored while held
    cur_req = "R6";
    rend = 1'b1; cyc(1); rend = 1'b0; cyc(3);      // extra end edge ignored
    cur_req = "R7";
    onset = 1'b1; collect = 1'b1; cyc(1);          // onset in collect cycle
    collect = 1'b0; onset = 1'b0; cyc(4);
    cur_req = "R8";
    collect = 1'b1; cyc(2); collect = 1'b0; cyc(2);  // stray collect while idle
    cur_req = "R9";
    onset = 1'b1; cyc(6); rend = 1'b1; cyc(1); rend = 1'b0; cyc(2);
    collect = 1'b1; cyc(1); collect = 1'b0; cyc(8); // onset still high: no rerun
    onset = 1'b0; cyc(2);
    cur_req = "R2";
    ts_sc = 2'd1; cyc(7);
    measure(12, 3, 1); collect_now();
    cyc(10);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd_hit = 1'b1; end
    join_any
    if (wd_hit) begin
      fails++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule